// File: doc/BRIEF.md
# Windowed Change Checker with Restart Policy

This block is a synthesizable assertion monitor. It watches a multi-bit test expression and flags a failure when that expression stays at one value for the whole of a fixed-length checking window. A start event opens the window. The value on the bus at that edge is kept as the reference. The window then runs for a set number of clock edges, and each of those edges compares the bus with the reference. When the window closes without any difference having been seen, the block raises a one-cycle failure pulse.

A two-state controller runs the block. One state waits for a start event and the other checks while the window is open. A build-time policy decides what a start event does when it arrives during an open window. In ignore mode the event is dropped. In restart mode the old window is abandoned and a fresh window begins at once. In error mode the event is dropped and a failure is flagged. The block is meant to sit next to design logic, fed from design signals, with its failure pulse routed to whatever collects errors.

Top module: `win_change_checker`

## Requirements
- R1: During and right after a synchronous active-low reset, `win_active` and `fail_pulse` are both 0.
- R2: A window opens only when `start_event` is high at a clock edge while no window is open. `win_active` is 1 from the next cycle on. Bus activity alone never opens a window or raises `fail_pulse`.
- R3: If no restart occurs, `win_active` stays high for exactly `WIN_CKS` cycles after the opening edge and then drops.
- R4: If the bus differs from the reference on any evaluated edge of the window, the window ends quietly. Otherwise `fail_pulse` is 1 for the single cycle in which `win_active` first reads 0.
- R5: The opening edge is not evaluated. Its bus value becomes the reference, so a change that lands exactly at the opening edge does not count.
- R6: The closing edge (the `WIN_CKS`-th edge after opening) is evaluated. A difference seen only on that edge prevents the failure.
- R7: With `POLICY` = 0 (ignore), a start event during an open window has no effect, even on the closing edge. The window ends at its original time, with its original reference.
- R8: With `POLICY` = 1 (restart), a start event during an open window reloads the window to a full `WIN_CKS` cycles, takes the bus value at that edge as the new reference, and discards what the old window had seen.
- R9: On a restart edge, the bus is not compared with the old reference, and no failure is reported for the old window, even when that edge would have closed it.
- R10: With `POLICY` = 2 (error), a start event during an open window raises `fail_pulse` in the next cycle. The window continues with its original timing and reference.
- R11: In ignore and restart modes, `fail_pulse` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_event | input | 1 | Request to open a checking window |
| test_expr | input | DATA_W | Bus being watched for a change |
| fail_pulse | output | 1 | One-cycle failure indication |
| win_active | output | 1 | High while a checking window is open |

## Verification
The bench builds three copies of the block with `DATA_W` = 8 and `WIN_CKS` = 4, one for each policy value. All three are driven from the same stimulus, so a single start event inside a window exposes how ignore, restart and error behaviour differ on the same cycle. A window length of four places the opening, middle, closing and restart edges a few cycles apart. This puts within reach a start event on the closing edge, a change that appears only on the opening or only on the closing edge, and windows that run back to back.

// File: rtl/wcc_pkg.sv
// Shared types for the windowed change checker.
// Assumes: included first in compile order.
package wcc_pkg;

    // Action taken for a start event seen while a window is open.
    typedef enum logic [1:0] {
        POL_IGNORE  = 2'd0,
        POL_RESTART = 2'd1,
        POL_ERROR   = 2'd2
    } policy_e;

    // Controller states: waiting for a start, or checking an open window.
    typedef enum logic {
        ST_WAIT  = 1'b0,
        ST_CHECK = 1'b1
    } state_e;

endpackage

// File: rtl/wcc_timer.sv
// Window length down-counter.
// Loads WIN_CKS when a window opens or restarts, then counts down once per
// edge while the window runs. last_o marks the edge that closes the window.
// Assumes: WIN_CKS >= 1; load_i and run_i never both high.
module wcc_timer #(
    parameter int unsigned WIN_CKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    input  logic active_i,
    output logic last_o
);
    localparam int unsigned CNT_W = $clog2(WIN_CKS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIN_CKS);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on open/restart, otherwise step down while the window runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_FULL;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // The closing edge is the one where a single count remains.
    assign last_o = (cnt_q == CNT_ONE);

    // R3: while a window is open the remaining count lies within 1..WIN_CKS.
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> ((cnt_q >= CNT_ONE) && (cnt_q <= CNT_FULL)));

endmodule

// File: rtl/wcc_tracker.sv
// Reference capture and change tracking.
// Captures the bus at the opening (or restart) edge and keeps a sticky flag
// of any difference seen on an evaluated edge. seen_o includes the current
// edge's comparison so the closing edge counts.
// Assumes: eval_i is only high while a window is open and not reloading.
module wcc_tracker #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              eval_i,
    input  logic [DATA_W-1:0] test_i,
    output logic              seen_o
);
    logic [DATA_W-1:0] ref_q;
    logic              seen_q;
    logic              diff_now;

    // Current edge's comparison against the stored reference.
    assign diff_now = (test_i != ref_q);
    assign seen_o   = seen_q | diff_now;

    // Take a new reference on load; accumulate differences on evaluated edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            seen_q <= 1'b0;
        end else if (load_i) begin
            ref_q  <= test_i;
            seen_q <= 1'b0;
        end else if (eval_i) begin
            seen_q <= seen_q | diff_now;
        end
    end

    // R8: a freshly loaded window starts with no recorded difference.
    p_fresh_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !seen_q);

endmodule

// File: rtl/wcc_ctrl.sv
// Two-state window controller with the new-start policy.
// Decides when to open, restart or close a window, when the bus is
// evaluated, and when a failure is reported (registered, one cycle later).
// Assumes: last_i and seen_i come from the timer and tracker of this window.
module wcc_ctrl
    import wcc_pkg::*;
#(
    parameter policy_e POLICY = POL_IGNORE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_i,
    input  logic seen_i,
    output logic load_o,
    output logic run_o,
    output logic eval_o,
    output logic active_o,
    output logic fail_o
);
    state_e state_q;
    state_e state_d;
    logic   fail_q;
    logic   fail_d;
    logic   restart_hit;
    logic   error_hit;
    logic   closing;

    // Classify a start event seen during an open window by policy.
    always_comb begin
        restart_hit = 1'b0;
        error_hit   = 1'b0;
        if (state_q == ST_CHECK && start_i) begin
            restart_hit = (POLICY == POL_RESTART);
            error_hit   = (POLICY == POL_ERROR);
        end
    end

    // Next state, load/evaluate strobes and failure decision.
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        run_o   = 1'b0;
        eval_o  = 1'b0;
        closing = 1'b0;
        fail_d  = 1'b0;
        if (state_q == ST_WAIT) begin
            if (start_i) begin
                load_o  = 1'b1;
                state_d = ST_CHECK;
            end
        end else if (restart_hit) begin
            load_o = 1'b1;
        end else begin
            run_o   = 1'b1;
            eval_o  = 1'b1;
            closing = last_i;
            fail_d  = error_hit | (last_i & ~seen_i);
            if (closing) begin
                state_d = ST_WAIT;
            end
        end
    end

    // State and registered failure pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fail_q  <= fail_d;
        end
    end

    assign active_o = (state_q == ST_CHECK);
    assign fail_o   = fail_q;

    // R2: without a start event a waiting controller stays waiting.
    p_open_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !start_i) |=> !active_o);

    // R2: no failure can follow an idle cycle with no start event.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !start_i) |=> !fail_o);

    // R7: in ignore mode a start before the closing edge keeps the window open.
    p_ignore_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY == POL_IGNORE && active_o && start_i && !last_i) |=> active_o);

    // R9: a restart keeps the window open and reports nothing for the old one.
    p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY == POL_RESTART && active_o && start_i) |=> (active_o && !fail_o));

    // R10: in error mode a start during a window is flagged next cycle.
    p_error_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY == POL_ERROR && active_o && start_i) |=> fail_o);

    // R11: outside error mode a failure lasts a single cycle.
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY != POL_ERROR && fail_o) |=> !fail_o);

endmodule

// File: rtl/win_change_checker.sv
// Windowed change checker (top).
// Opens a window on start_event, keeps the bus value at that edge, and
// pulses fail_pulse if the bus never differs from it over the next WIN_CKS
// edges. POLICY selects ignore, restart or error for starts during a window.
// Assumes: WIN_CKS >= 1, DATA_W >= 1, inputs synchronous to clk.
module win_change_checker
    import wcc_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned WIN_CKS = 4,
    parameter policy_e     POLICY  = POL_IGNORE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_event,
    input  logic [DATA_W-1:0] test_expr,
    output logic              fail_pulse,
    output logic              win_active
);
    logic load_w;
    logic run_w;
    logic eval_w;
    logic last_w;
    logic seen_w;

    wcc_ctrl #(.POLICY(POLICY)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_event),
        .last_i   (last_w),
        .seen_i   (seen_w),
        .load_o   (load_w),
        .run_o    (run_w),
        .eval_o   (eval_w),
        .active_o (win_active),
        .fail_o   (fail_pulse)
    );

    wcc_timer #(.WIN_CKS(WIN_CKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .run_i    (run_w),
        .active_i (win_active),
        .last_o   (last_w)
    );

    wcc_tracker #(.DATA_W(DATA_W)) u_tracker (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .eval_i (eval_w),
        .test_i (test_expr),
        .seen_o (seen_w)
    );

    // R1: a reset cycle leaves the outputs low on the following cycle.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!win_active && !fail_pulse));

endmodule

// File: tb/tb_win_change_checker.sv
// Scoreboard bench: the driver applies one cycle of stimulus to three copies
// (ignore, restart, error), computes expected outputs from the requirements
// and queues them; the monitor pops and compares after each rising edge.
module tb_win_change_checker;
    import wcc_pkg::*;

    localparam int unsigned DW = 8;
    localparam int unsigned NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_event = 1'b0;
    logic [DW-1:0] test_expr = '0;
    logic [2:0]    fail_v;
    logic [2:0]    act_v;

    always #2.5 clk = ~clk;

    win_change_checker #(.DATA_W(DW), .WIN_CKS(NC), .POLICY(POL_IGNORE)) dut (
        .clk(clk), .rst_n(rst_n), .start_event(start_event), .test_expr(test_expr),
        .fail_pulse(fail_v[0]), .win_active(act_v[0]));
    win_change_checker #(.DATA_W(DW), .WIN_CKS(NC), .POLICY(POL_RESTART)) dut_restart (
        .clk(clk), .rst_n(rst_n), .start_event(start_event), .test_expr(test_expr),
        .fail_pulse(fail_v[1]), .win_active(act_v[1]));
    win_change_checker #(.DATA_W(DW), .WIN_CKS(NC), .POLICY(POL_ERROR)) dut_error (
        .clk(clk), .rst_n(rst_n), .start_event(start_event), .test_expr(test_expr),
        .fail_pulse(fail_v[2]), .win_active(act_v[2]));

    typedef struct {
        logic [2:0] act;
        logic [2:0] fail;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    // Expected-behaviour state per policy (0 ignore, 1 restart, 2 error).
    bit       m_act[3];
    int       m_cnt[3];
    logic [DW-1:0] m_ref[3];
    bit       m_seen[3];
    bit       m_fail[3];

    // One clock of stimulus; the expectation for the following edge is queued.
    task automatic step(input bit rst, input bit st, input logic [DW-1:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = ~rst;
        start_event = st;
        test_expr = v;
        for (int p = 0; p < 3; p++) begin
            if (rst) begin
                m_act[p] = 0; m_fail[p] = 0; m_cnt[p] = 0; m_seen[p] = 0;
            end else if (!m_act[p]) begin
                m_fail[p] = 0;
                if (st) begin
                    m_act[p] = 1; m_cnt[p] = NC; m_ref[p] = v; m_seen[p] = 0;
                end
            end else if (st && p == 1) begin
                m_fail[p] = 0; m_cnt[p] = NC; m_ref[p] = v; m_seen[p] = 0;
            end else begin
                bit ch;
                ch = m_seen[p] | (v != m_ref[p]);
                m_fail[p] = (st && p == 2);
                if (m_cnt[p] == 1) begin
                    m_fail[p] = m_fail[p] | !ch;
                    m_act[p] = 0;
                end
                m_seen[p] = ch;
                m_cnt[p] = m_cnt[p] - 1;
            end
            e.act[p] = m_act[p];
            e.fail[p] = m_fail[p];
        end
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare every copy's outputs shortly after the edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            for (int p = 0; p < 3; p++) begin
                checks++;
                if (act_v[p] !== e.act[p]) begin
                    failures++;
                    $display("FAIL %s policy=%0d win_active got=%b exp=%b", e.tag, p, act_v[p], e.act[p]);
                end
                checks++;
                if (fail_v[p] !== e.fail[p]) begin
                    failures++;
                    $display("FAIL %s policy=%0d fail_pulse got=%b exp=%b", e.tag, p, fail_v[p], e.fail[p]);
                end
            end
        end
    end

    // Hold a value with no start for n cycles.
    task automatic idle(input int n, input logic [DW-1:0] v, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, v, tag);
    endtask

    initial begin
        // R1: reset state
        step(1, 0, 8'h00, "R1");
        step(1, 1, 8'h11, "R1");
        // R2: bus activity with no start opens nothing
        step(0, 0, 8'h01, "R2"); step(0, 0, 8'h02, "R2"); step(0, 0, 8'h03, "R2");
        // R3/R4: unchanged bus for the whole window -> failure after close
        step(0, 1, 8'h05, "R3"); idle(NC, 8'h05, "R4"); idle(2, 8'h05, "R4");
        // R4: mid-window change that reverts -> quiet close
        step(0, 1, 8'h05, "R4"); step(0, 0, 8'h06, "R4"); idle(NC, 8'h05, "R4");
        // R5: change exactly at the opening edge does not count
        step(0, 0, 8'h01, "R5"); step(0, 1, 8'h02, "R5"); idle(NC + 1, 8'h02, "R5");
        // R6: difference only on the closing edge prevents failure
        step(0, 1, 8'h07, "R6"); idle(NC - 1, 8'h07, "R6"); step(0, 0, 8'h09, "R6");
        idle(2, 8'h09, "R6");
        // R7/R8/R10: start in mid-window on a constant bus, per policy
        step(0, 1, 8'h33, "R7"); step(0, 0, 8'h33, "R8"); step(0, 1, 8'h33, "R10");
        idle(NC + 2, 8'h33, "R8");
        // R9: restart edge brings a new value; old window's change discarded
        step(0, 1, 8'h03, "R9"); step(0, 0, 8'h03, "R9"); step(0, 1, 8'h07, "R9");
        idle(NC + 2, 8'h07, "R9");
        // R7/R9: start on the closing edge (restart edge suppresses old close)
        step(0, 1, 8'h44, "R7"); idle(NC - 1, 8'h44, "R7"); step(0, 1, 8'h44, "R9");
        idle(NC + 2, 8'h44, "R9");
        // R11: back-to-back failing windows give separate single pulses
        step(0, 1, 8'h55, "R11"); idle(NC, 8'h55, "R11");
        step(0, 1, 8'h55, "R11"); idle(NC + 2, 8'h55, "R11");
        // R10: repeated starts in error mode, then reset mid-window (R1)
        step(0, 1, 8'h66, "R10"); step(0, 1, 8'h67, "R10"); step(0, 0, 8'h67, "R10");
        step(1, 0, 8'h67, "R1"); idle(3, 8'h67, "R1");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule